// File: doc/BRIEF.md
# Interrupt Redirection Router

This block routes up to 24 interrupt input pins to processors. Each pin has a 64-bit routing entry. The entry holds the vector, the delivery mode, the destination mode, the input polarity, the trigger mode, a mask flag and an 8-bit destination. When an input line changes, the block gets an event carrying the line number and the new level. The block marks a pin pending on a rising edge, or while the level is high, depending on that pin's trigger mode. For the lowest-numbered pending pin that is allowed to fire, it emits a delivery message on a valid/ready output.

Software does not see the entries directly. It reaches them through two bus offsets. A write to offset 0x00 selects a register index. Offset 0x10 is a 32-bit window onto the selected register. The index space holds:

- an identification register,
- a read-only version register,
- two indices per entry, one for each 32-bit half.

The block that consumes the message, and how a processor decodes it, sit outside this design.

Top module: `intr_route_table`

## Requirements
- R1: A synchronous active-high reset returns the following values:
  - index register 0;
  - identification 0;
  - every entry 0x00000000_00010000, which is masked with all other fields zero;
  - no pending pin;
  - msg_valid low.
- R2: A write at bus offset 0x00 loads the 8-bit index from bus_wdata[7:0], and reading offset 0x00 returns that index. Offset 0x10 reads or writes the register the index selects. Reads are combinational from bus_addr.
- R3: Index 0 holds an 8-bit identifier in bits 31:24; its other bits read as zero. Index 1 reads 0x00170011, made of version 0x11 in bits 7:0 and the pin count minus one (23) in bits 23:16. Writes to index 1 have no effect.
- R4: Index 0x10+2p selects the low 32 bits of the entry for pin p, and index 0x11+2p selects its high 32 bits, for p from 0 to 23. A write to one half leaves the other half unchanged.
- R5: Reads return zero in two cases:
  - indices 0x02 to 0x0F and 0x40 to 0xFF;
  - bus offsets other than 0x00 and 0x10.

  Writes to those indices change no register.
- R6: The entry fields and the message fields match as follows:

  | Field | Entry bits | Message port |
  |---|---|---|
  | vector | 7:0 | msg_vector |
  | delivery mode | 10:8 | msg_deliv_mode |
  | destination mode | 11 | msg_dest_mode |
  | polarity | 13 | msg_polarity |
  | trigger mode, 1 meaning level | 15 | msg_trig_level |
  | mask | 16 | (no port) |
  | destination | 63:56 | msg_dest |
- R7: For an edge pin (bit 15 = 0), only a low-to-high level change sets the pending bit. Dispatch clears the bit, so each rising edge gives exactly one message. A repeated high event gives none.
- R8: For a level pin (bit 15 = 1), the pending bit follows the last reported level. Deasserting before dispatch cancels the request. Once a level pin has been delivered, it is not delivered again until its line goes low and then high again.
- R9: A pin whose mask bit 16 is set is never delivered, but it keeps its pending state. Clearing the mask later delivers the pending request.
- R10: When several pins may fire, the lowest pin number is delivered first.
- R11: Line number 0 drives pin 2. Line numbers 1 to 23 drive the pin with the same number. Line numbers of 24 and above are ignored.
- R12: msg_valid rises on the second rising edge after an event is applied, and on the first rising edge after an unmasking write. A message stays stable while msg_ready is low. A handshake edge may load the next message at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Bus offset: 0x00 selects the index register, 0x10 selects the data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| line_valid | input | 1 | Input line event strobe |
| line_num | input | 8 | Input line number of the event |
| line_level | input | 1 | New level of that line |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity |
| msg_trig_level | output | 1 | Trigger mode (1 = level) |

## Verification
- **Line events.** An event presented before rising edge N updates the pending state at N. The message register captures it at edge N+1. The bench checks msg_valid low just after edge N and the full message just after edge N+1.
- **Register reads.** A write is visible on the combinational read right after its own edge.
- **Unmasking.** Clearing a mask yields a message one edge after the write.
- **Handshake.** A handshake at an edge replaces the message at that same edge.

All outputs are sampled at falling edges, half a period after the edge that is due to change them. This lets each check target the exact cycle instead of waiting loosely.

// File: rtl/intr_route_pkg.sv
`timescale 1ns/1ps
package intr_route_pkg;

    localparam int ENTRY_W = 64;
    localparam int WORD_W  = 32;

    localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef struct packed {
        logic [7:0] dest;
        logic       dest_mode;
        logic [2:0] deliv_mode;
        logic [7:0] vector;
        logic       polarity;
        logic       trig_level;
    } route_msg_t;

    typedef struct packed {
        logic       masked;
        route_msg_t msg;
    } entry_view_t;

    typedef enum logic [1:0] {
        REG_IDENT,
        REG_VERSION,
        REG_ENTRY,
        REG_NONE
    } reg_kind_e;

    function automatic entry_view_t decode_entry(input logic [ENTRY_W-1:0] e);
        entry_view_t v;
        v.masked         = e[16];
        v.msg.dest       = e[63:56];
        v.msg.dest_mode  = e[11];
        v.msg.deliv_mode = e[10:8];
        v.msg.vector     = e[7:0];
        v.msg.polarity   = e[13];
        v.msg.trig_level = e[15];
        return v;
    endfunction

    function automatic logic entry_is_level(input logic [ENTRY_W-1:0] e);
        return e[15];
    endfunction

endpackage

// File: rtl/intr_route_regs.sv
`timescale 1ns/1ps
module intr_route_regs
    import intr_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W   = 8,
    parameter int IDX_W    = 8,
    parameter int SEL_OFF  = 0,
    parameter int WIN_OFF  = 16,
    parameter int WIN_BASE = 16,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_wen,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [WORD_W-1:0]                 bus_wdata,
    output logic [WORD_W-1:0]                 bus_rdata,
    output logic [IDX_W-1:0]                  sel_idx,
    output logic [NUM_PINS-1:0][ENTRY_W-1:0]  entries
);

    localparam int PIN_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int ENTRY_LAST = WIN_BASE + 2 * NUM_PINS - 1;

    logic [IDX_W-1:0] sel_q;
    logic [7:0]       ident_q;
    logic [IDX_W-1:0] rel;
    logic [PIN_W-1:0] slot;
    logic             upper;
    reg_kind_e        kind;
    logic             sel_wr;
    logic             win_wr;
    logic [WORD_W-1:0] win_rd;

    always_comb begin
        rel   = sel_q - IDX_W'(WIN_BASE);
        slot  = rel[PIN_W:1];
        upper = rel[0];
        if (sel_q == '0)
            kind = REG_IDENT;
        else if (sel_q == IDX_W'(1))
            kind = REG_VERSION;
        else if (int'(sel_q) >= WIN_BASE && int'(sel_q) <= ENTRY_LAST)
            kind = REG_ENTRY;
        else
            kind = REG_NONE;
    end

    assign sel_wr = bus_wen && (bus_addr == ADDR_W'(SEL_OFF));
    assign win_wr = bus_wen && (bus_addr == ADDR_W'(WIN_OFF));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            ident_q <= '0;
        end else begin
            if (sel_wr)
                sel_q <= bus_wdata[IDX_W-1:0];
            if (win_wr && kind == REG_IDENT)
                ident_q <= bus_wdata[31:24];
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
        logic             hit;
        logic [ENTRY_W-1:0] ent_q;

        assign hit = win_wr && (kind == REG_ENTRY) && (slot == PIN_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= ENTRY_RESET;
            end else if (hit) begin
                if (upper)
                    ent_q[ENTRY_W-1:WORD_W] <= bus_wdata;
                else
                    ent_q[WORD_W-1:0] <= bus_wdata;
            end
        end

        assign entries[p] = ent_q;
    end

    always_comb begin
        win_rd = '0;
        case (kind)
            REG_IDENT:   win_rd = {ident_q, 24'd0};
            REG_VERSION: win_rd = {8'd0, 8'(NUM_PINS - 1), 8'd0, VERSION};
            REG_ENTRY:   win_rd = upper ? entries[slot][ENTRY_W-1:WORD_W]
                                        : entries[slot][WORD_W-1:0];
            default:     win_rd = '0;
        endcase

        if (bus_addr == ADDR_W'(SEL_OFF))
            bus_rdata = WORD_W'(sel_q);
        else if (bus_addr == ADDR_W'(WIN_OFF))
            bus_rdata = win_rd;
        else
            bus_rdata = '0;
    end

    assign sel_idx = sel_q;

endmodule

// File: rtl/intr_route_pins.sv
`timescale 1ns/1ps
module intr_route_pins #(
    parameter int NUM_PINS   = 24,
    parameter int LINE_W     = 8,
    parameter int ALIAS_LINE = 0,
    parameter int ALIAS_PIN  = 2,
    localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_valid,
    input  logic [LINE_W-1:0]   line_num,
    input  logic                line_level,
    input  logic [NUM_PINS-1:0] level_mode,
    input  logic                take_valid,
    input  logic [PIN_W-1:0]    take_pin,
    output logic [NUM_PINS-1:0] pending,
    output logic [NUM_PINS-1:0] spent
);

    logic             in_range;
    logic [PIN_W-1:0] pin;

    always_comb begin
        in_range = int'(line_num) < NUM_PINS;
        if (int'(line_num) == ALIAS_LINE)
            pin = PIN_W'(ALIAS_PIN);
        else
            pin = line_num[PIN_W-1:0];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic hit;
        logic took;
        logic lvl_q;
        logic pend_q;
        logic spent_q;

        assign hit  = line_valid && in_range && (pin == PIN_W'(p));
        assign took = take_valid && (take_pin == PIN_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q   <= 1'b0;
                pend_q  <= 1'b0;
                spent_q <= 1'b0;
            end else begin
                if (hit)
                    lvl_q <= line_level;
                if (level_mode[p]) begin
                    if (hit)
                        pend_q <= line_level;
                    if (hit && !line_level)
                        spent_q <= 1'b0;
                    else if (took)
                        spent_q <= 1'b1;
                end else begin
                    if (hit && line_level && !lvl_q)
                        pend_q <= 1'b1;
                    else if (took)
                        pend_q <= 1'b0;
                    spent_q <= 1'b0;
                end
            end
        end

        assign pending[p] = pend_q;
        assign spent[p]   = spent_q;
    end

endmodule

// File: rtl/intr_route_dispatch.sv
`timescale 1ns/1ps
module intr_route_dispatch
    import intr_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PINS-1:0]              pending,
    input  logic [NUM_PINS-1:0]              spent,
    input  logic [NUM_PINS-1:0][ENTRY_W-1:0] entries,
    input  logic                             out_ready,
    output logic                             out_valid,
    output route_msg_t                       out_msg,
    output logic                             take_valid,
    output logic [PIN_W-1:0]                 take_pin
);

    entry_view_t         view [NUM_PINS];
    logic [NUM_PINS-1:0] eligible;
    logic [PIN_W-1:0]    pick;
    logic                any;
    logic                load;
    logic                valid_q;
    route_msg_t          msg_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_view
        assign view[p]     = decode_entry(entries[p]);
        assign eligible[p] = pending[p] && !view[p].masked
                             && !(view[p].msg.trig_level && spent[p]);
    end

    always_comb begin
        pick = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (eligible[i])
                pick = PIN_W'(i);
        end
    end

    assign any        = |eligible;
    assign load       = !valid_q || out_ready;
    assign take_valid = load && any;
    assign take_pin   = pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else if (load) begin
            valid_q <= any;
            if (any)
                msg_q <= view[pick].msg;
        end
    end

    assign out_valid = valid_q;
    assign out_msg   = msg_q;

endmodule

// File: rtl/intr_route_table.sv
`timescale 1ns/1ps
module intr_route_table
    import intr_route_pkg::*;
#(
    parameter int NUM_PINS   = 24,
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 8,
    parameter int LINE_W     = 8,
    parameter int SEL_OFF    = 0,
    parameter int WIN_OFF    = 16,
    parameter int WIN_BASE   = 16,
    parameter int ALIAS_LINE = 0,
    parameter int ALIAS_PIN  = 2,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              line_valid,
    input  logic [LINE_W-1:0] line_num,
    input  logic              line_level,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_dest,
    output logic              msg_dest_mode,
    output logic [2:0]        msg_deliv_mode,
    output logic [7:0]        msg_vector,
    output logic              msg_polarity,
    output logic              msg_trig_level
);

    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0][ENTRY_W-1:0] entries;
    logic [IDX_W-1:0]                 sel_idx;
    logic [NUM_PINS-1:0]              level_mode;
    logic [NUM_PINS-1:0]              pending;
    logic [NUM_PINS-1:0]              spent;
    logic                             take_valid;
    logic [PIN_W-1:0]                 take_pin;
    route_msg_t                       out_msg;

    intr_route_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .SEL_OFF  (SEL_OFF),
        .WIN_OFF  (WIN_OFF),
        .WIN_BASE (WIN_BASE),
        .VERSION  (VERSION)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sel_idx   (sel_idx),
        .entries   (entries)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
        assign level_mode[p] = entry_is_level(entries[p]);
    end

    intr_route_pins #(
        .NUM_PINS   (NUM_PINS),
        .LINE_W     (LINE_W),
        .ALIAS_LINE (ALIAS_LINE),
        .ALIAS_PIN  (ALIAS_PIN)
    ) i_pins (
        .clk        (clk),
        .rst        (rst),
        .line_valid (line_valid),
        .line_num   (line_num),
        .line_level (line_level),
        .level_mode (level_mode),
        .take_valid (take_valid),
        .take_pin   (take_pin),
        .pending    (pending),
        .spent      (spent)
    );

    intr_route_dispatch #(
        .NUM_PINS (NUM_PINS)
    ) i_dispatch (
        .clk        (clk),
        .rst        (rst),
        .pending    (pending),
        .spent      (spent),
        .entries    (entries),
        .out_ready  (msg_ready),
        .out_valid  (msg_valid),
        .out_msg    (out_msg),
        .take_valid (take_valid),
        .take_pin   (take_pin)
    );

    assign msg_dest       = out_msg.dest;
    assign msg_dest_mode  = out_msg.dest_mode;
    assign msg_deliv_mode = out_msg.deliv_mode;
    assign msg_vector     = out_msg.vector;
    assign msg_polarity   = out_msg.polarity;
    assign msg_trig_level = out_msg.trig_level;

endmodule

// File: rtl/intr_route_chk.sv
`timescale 1ns/1ps
module intr_route_chk #(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W   = 8,
    parameter int IDX_W    = 8,
    parameter int SEL_OFF  = 0,
    parameter int WIN_OFF  = 16,
    parameter logic [7:0] VERSION = 8'h11
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [IDX_W-1:0]    sel_idx,
    input logic [NUM_PINS-1:0] pending,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [21:0]         msg_bits
);

    localparam logic [31:0] VERSION_WORD = {8'd0, 8'(NUM_PINS - 1), 8'd0, VERSION};

    // R12
    hold_msg_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_bits));

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !msg_valid);

    // R3
    version_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(WIN_OFF) && sel_idx == IDX_W'(1)) |-> bus_rdata == VERSION_WORD);

    // R5
    unmapped_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != ADDR_W'(SEL_OFF) && bus_addr != ADDR_W'(WIN_OFF)) |-> bus_rdata == 32'd0);

    // R7
    msg_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $past(|pending));

endmodule

bind intr_route_table intr_route_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .SEL_OFF  (SEL_OFF),
    .WIN_OFF  (WIN_OFF),
    .VERSION  (VERSION)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sel_idx   (sel_idx),
    .pending   (pending),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_bits  ({msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_polarity, msg_trig_level})
);

// File: tb/test_intr_route_table.sv
`timescale 1ns/1ps
module test_intr_route_table;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        line_valid = 1'b0;
    logic [7:0]  line_num = '0;
    logic        line_level = 1'b0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_dest;
    logic        msg_dest_mode;
    logic [2:0]  msg_deliv_mode;
    logic [7:0]  msg_vector;
    logic        msg_polarity;
    logic        msg_trig_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    intr_route_table i_intr_route_table (
        .clk            (clk),
        .rst            (rst),
        .bus_wen        (bus_wen),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .line_valid     (line_valid),
        .line_num       (line_num),
        .line_level     (line_level),
        .msg_valid      (msg_valid),
        .msg_ready      (msg_ready),
        .msg_dest       (msg_dest),
        .msg_dest_mode  (msg_dest_mode),
        .msg_deliv_mode (msg_deliv_mode),
        .msg_vector     (msg_vector),
        .msg_polarity   (msg_polarity),
        .msg_trig_level (msg_trig_level)
    );

    function automatic logic [21:0] exp_msg(input logic [31:0] lo, input logic [31:0] hi);
        return {hi[31:24], lo[11], lo[10:8], lo[7:0], lo[13], lo[15]};
    endfunction

    function automatic logic [21:0] got_msg();
        return {msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_polarity, msg_trig_level};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 8'h10;
    endtask

    task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d);
        wr(8'h00, {24'd0, idx});
        wr(8'h10, d);
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
        wr(8'h00, {24'd0, idx});
        bus_addr = 8'h10;
        #1 d = bus_rdata;
    endtask

    task automatic set_pin(input int p, input logic [31:0] lo, input logic [31:0] hi);
        wr_idx(8'(8'h11 + 2 * p), hi);
        wr_idx(8'(8'h10 + 2 * p), lo);
    endtask

    task automatic ev(input logic [7:0] n, input logic l);
        @(negedge clk);
        line_valid = 1'b1; line_num = n; line_level = l;
        @(negedge clk);
        line_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] model [24];
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 24; i++) model[i] = 64'h0000_0000_0001_0000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 msg_valid after reset", msg_valid, 0);
        bus_addr = 8'h00; #1;
        check("R1 index after reset", bus_rdata, 0);
        rd_idx(8'h00, r); check("R1 ident after reset", r, 0);
        rd_idx(8'h10, r); check("R1 entry0 low after reset", r, 32'h0001_0000);
        rd_idx(8'h3F, r); check("R1 entry23 high after reset", r, 0);

        // R2 index readback
        wr(8'h00, 32'hFFFF_FF27);
        bus_addr = 8'h00; #1;
        check("R2 index readback", bus_rdata, 32'h27);

        // R3 identification and version
        wr_idx(8'h00, 32'hA5FF_FFFF);
        rd_idx(8'h00, r); check("R3 ident write", r, 32'hA500_0000);
        wr_idx(8'h01, 32'hFFFF_FFFF);
        rd_idx(8'h01, r); check("R3 version read-only", r, 32'h0017_0011);

        // R5 unimplemented indices and offsets
        wr_idx(8'h40, 32'hDEAD_BEEF);
        rd_idx(8'h40, r); check("R5 index 0x40 reads zero", r, 0);
        rd_idx(8'h3E, r); check("R5 write to 0x40 leaves entry23", r, 32'h0001_0000);
        wr_idx(8'h05, 32'h1234_5678);
        rd_idx(8'h05, r); check("R5 index 0x05 reads zero", r, 0);
        rd_idx(8'h00, r); check("R5 ident untouched", r, 32'hA500_0000);
        wr(8'h00, 32'h10);
        bus_addr = 8'h04; #1;
        check("R5 other offset reads zero", bus_rdata, 0);

        // R4 halves independent
        wr_idx(8'h13, 32'hCAFE_0001);
        wr_idx(8'h12, 32'h0001_1111);
        wr_idx(8'h12, 32'h0001_2222);
        rd_idx(8'h13, r); check("R4 high half kept", r, 32'hCAFE_0001);
        rd_idx(8'h12, r); check("R4 low half rewritten", r, 32'h0001_2222);
        model[1] = 64'hCAFE_0001_0001_2222;

        // R4 random register traffic against a model
        for (int k = 0; k < 40; k++) begin
            int p = $urandom_range(0, 23);
            logic hi_sel = 1'($urandom_range(0, 1));
            logic [31:0] d = $urandom;
            if (!hi_sel) d = d | 32'h0001_0000;
            wr_idx(8'(8'h10 + 2 * p + int'(hi_sel)), d);
            if (hi_sel) model[p][63:32] = d; else model[p][31:0] = d;
            p = $urandom_range(0, 23);
            rd_idx(8'(8'h10 + 2 * p), r); check("R4 random low readback", r, model[p][31:0]);
            rd_idx(8'(8'h11 + 2 * p), r); check("R4 random high readback", r, model[p][63:32]);
        end
        check("R9 masked random entries gave no message", msg_valid, 0);

        // R7 R6 R12 edge pin 5
        set_pin(5, 32'h0000_2B41, 32'h7E00_0000);
        ev(8'd5, 1'b1);
        check("R12 no message one edge after event", msg_valid, 0);
        @(negedge clk);
        check("R12 message two edges after event", msg_valid, 1);
        check("R6 edge message fields", got_msg(), exp_msg(32'h0000_2B41, 32'h7E00_0000));
        repeat (3) @(negedge clk);
        check("R12 message held without ready", got_msg(), exp_msg(32'h0000_2B41, 32'h7E00_0000));
        pop();
        check("R7 edge pin cleared after dispatch", msg_valid, 0);
        ev(8'd5, 1'b1);
        @(negedge clk);
        check("R7 repeated high gives no message", msg_valid, 0);
        ev(8'd5, 1'b0);
        ev(8'd5, 1'b1);
        @(negedge clk);
        check("R7 new rising edge delivers", msg_valid, 1);
        pop();
        ev(8'd5, 1'b0);

        // R8 level pin 7
        set_pin(7, 32'h0000_8062, 32'h0100_0000);
        ev(8'd7, 1'b1);
        @(negedge clk);
        check("R8 level message", got_msg(), exp_msg(32'h0000_8062, 32'h0100_0000));
        pop();
        repeat (3) @(negedge clk);
        check("R8 no re-delivery while held", msg_valid, 0);
        ev(8'd7, 1'b0);
        ev(8'd7, 1'b1);
        @(negedge clk);
        check("R8 re-delivery after reassert", msg_valid, 1);
        pop();
        ev(8'd7, 1'b0);
        wr_idx(8'h1E, 32'h0001_8062);
        ev(8'd7, 1'b1);
        ev(8'd7, 1'b0);
        wr_idx(8'h1E, 32'h0000_8062);
        repeat (2) @(negedge clk);
        check("R8 deassert before dispatch cancels", msg_valid, 0);
        wr_idx(8'h1E, 32'h0001_8062);
        ev(8'd7, 1'b1);
        wr_idx(8'h1E, 32'h0000_8062);
        @(negedge clk);
        check("R8 held level delivered on unmask", msg_valid, 1);
        pop();
        ev(8'd7, 1'b0);

        // R9 mask keeps pending
        set_pin(9, 32'h0001_0033, 32'h0200_0000);
        ev(8'd9, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 masked pin not delivered", msg_valid, 0);
        wr_idx(8'h22, 32'h0000_0033);
        check("R12 no message at unmask edge", msg_valid, 0);
        @(negedge clk);
        check("R9 unmask delivers pending", got_msg(), exp_msg(32'h0000_0033, 32'h0200_0000));
        pop();
        ev(8'd9, 1'b0);

        // R10 priority with a stalled output
        set_pin(20, 32'h0000_0054, 32'h0300_0000);
        set_pin(12, 32'h0000_004C, 32'h0400_0000);
        set_pin(4,  32'h0000_0044, 32'h0500_0000);
        ev(8'd20, 1'b1);
        @(negedge clk);
        check("R10 first message pin 20", msg_vector, 8'h54);
        ev(8'd12, 1'b1);
        ev(8'd4, 1'b1);
        check("R12 stalled message unchanged", msg_vector, 8'h54);
        pop();
        check("R10 lowest pin next", msg_vector, 8'h44);
        check("R12 back-to-back valid", msg_valid, 1);
        pop();
        check("R10 then pin 12", msg_vector, 8'h4C);
        pop();
        check("R10 queue drained", msg_valid, 0);
        ev(8'd20, 1'b0); ev(8'd12, 1'b0); ev(8'd4, 1'b0);

        // R11 alias and out-of-range lines
        set_pin(2, 32'h0000_0052, 32'h0600_0000);
        set_pin(8, 32'h0000_0048, 32'h0700_0000);
        ev(8'd0, 1'b1);
        @(negedge clk);
        check("R11 line 0 drives pin 2", msg_vector, 8'h52);
        pop();
        ev(8'd0, 1'b0);
        ev(8'd24, 1'b1);
        ev(8'd200, 1'b1);
        repeat (3) @(negedge clk);
        check("R11 lines 24 and up ignored", msg_valid, 0);
        ev(8'd24, 1'b0);
        ev(8'd200, 1'b0);

        // R6 R7 random edge deliveries
        for (int k = 0; k < 12; k++) begin
            int p = $urandom_range(1, 23);
            logic [31:0] lo = $urandom & 32'h0000_2FFF;
            logic [31:0] hi = $urandom;
            set_pin(p, lo, hi);
            ev(8'(p), 1'b1);
            @(negedge clk);
            check("R6 random message fields", got_msg(), exp_msg(lo, hi));
            pop();
            check("R7 random single delivery", msg_valid, 0);
            ev(8'(p), 1'b0);
            wr_idx(8'(8'h10 + 2 * p), lo | 32'h0001_0000);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule